// File: doc/BRIEF.md
# SPI Serial Memory Slave Engine

This block is the serial front end of a 512-byte memory. An SPI master selects it with an active-low chip select, shifts in one command byte and, depending on the command, an address and a run of data bytes. Data are written into or streamed out of an internal 512x8 register file. The address advances after every byte and wraps at the top of the array. The block works in SPI modes 0 and 3. It samples the serial input on the rising clock edge and changes the serial output on the falling edge, always most significant bit first.

All SPI pins are brought into the fast system clock through synchronisers, and the edges are found there; SCK never clocks a flop. Whether a data byte may be written is decided by a separate protection unit. The engine shows it the current byte address and reads back a grant. The engine only reports the write-enable commands and the status byte written by the master, and it returns the status byte that the protection unit offers. An active-low pause input freezes a transfer mid-stream without aborting it.

Top module: `spi_mem_slave`

## Requirements
- R1: Bits are taken on rising SCK and the output changes on falling SCK, MSB first. Transfers in mode 0 (SCK idles low) and in mode 3 (SCK idles high) give identical results.
- R2: Command 0x06 gives exactly one `wel_set_o` pulse and command 0x04 exactly one `wel_clr_o` pulse. Neither command takes any further byte.
- R3: Command 0x05 returns `sr_rdata_i` as the next byte. The output is high-impedance (`so_oe_o`=0) for any byte after that one.
- R4: Command 0x01 takes exactly one following byte and presents it on `sr_wdata_o` with a single `sr_wr_o` pulse.
- R5: Command bytes of the form 0000_A011 (read) and 0000_A010 (write) take bit 3 (A) as address bit 8. The following byte gives address bits 7..0.
- R6: In a write, each data byte enters the array right after its eighth bit, at the address shown on `wr_addr_o`, but only when `wr_grant_i` is high. A denied byte leaves that location unchanged. There is no limit on the number of bytes.
- R7: The address increments after every data byte in both reads and writes and wraps from 1FFh to 000h. In a read, SI is ignored after the address byte.
- R8: `so_oe_o` is high only while read data or status data is being returned. It is low during the command and address bytes and at all other times.
- R9: A rising chip select ends the operation. Only the first byte after a falling chip select is decoded as a command, and bytes after a completed command have no effect.
- R10: While hold is low, SCK and chip-select edges are ignored and `so_oe_o` is low. Raising hold (with SCK low) resumes the transfer where it stopped.
- R11: Any other command byte makes the engine ignore the rest of that selection, with the output kept high-impedance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, faster than SCK |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | SPI serial clock |
| cs_ni | input | 1 | Active-low chip select |
| si_i | input | 1 | Serial data in |
| hold_ni | input | 1 | Active-low pause |
| so_o | output | 1 | Serial data out |
| so_oe_o | output | 1 | Output enable for so_o (low = high-impedance) |
| wel_set_o | output | 1 | Pulse: set write-enable latch command seen |
| wel_clr_o | output | 1 | Pulse: clear write-enable latch command seen |
| sr_wr_o | output | 1 | Pulse: status byte received |
| sr_wdata_o | output | 8 | Status byte from the master |
| sr_rdata_i | input | 8 | Status byte to return on a status read |
| wr_addr_o | output | 9 | Current byte address, for the protection check |
| wr_grant_i | input | 1 | Protection unit permits a write at wr_addr_o |

## Verification
Streamed writes and reads that start just below the top of the array separate a correct wrap from a missing one or a wrap at the wrong width. The same data is run in both SPI modes, which shows whether the sampling edge and the driving edge are correct. Grant-denied bytes, unknown command bytes and trailing bytes after single-byte commands check that nothing is written or driven when it should not be. A hold placed in the middle of a read, with SCK toggling during the pause, separates a true freeze from a lost or extra bit.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_OP, ST_ADDR, ST_WDATA, ST_RDATA, ST_RDSR, ST_WRSR, ST_SKIP
  } st_e;

  localparam logic [7:0] CMD_LATCH_SET = 8'h06;
  localparam logic [7:0] CMD_LATCH_CLR = 8'h04;
  localparam logic [7:0] CMD_STAT_RD   = 8'h05;
  localparam logic [7:0] CMD_STAT_WR   = 8'h01;
endpackage

// File: rtl/spi_mem_sync.sv
module spi_mem_sync #(
  parameter int          W      = 4,
  parameter int          STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] r;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) r[0] <= RST_VAL;
    else         r[0] <= d_i;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) r[g] <= RST_VAL;
      else         r[g] <= r[g-1];
    end
  end

  assign q_o = r[STAGES-1];
endmodule

// File: rtl/spi_mem_array.sv
module spi_mem_array #(
  parameter int AW = 9,
  parameter int DW = 8,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we_i) begin
      mem[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/spi_mem_slave.sv
module spi_mem_slave
  import spi_mem_pkg::*;
#(
  parameter int AW = 9,
  parameter int DW = 8,
  parameter int SYNC_STAGES = 2,
  localparam int CW = $clog2(DW)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sck_i,
  input  logic          cs_ni,
  input  logic          si_i,
  input  logic          hold_ni,
  output logic          so_o,
  output logic          so_oe_o,
  output logic          wel_set_o,
  output logic          wel_clr_o,
  output logic          sr_wr_o,
  output logic [DW-1:0] sr_wdata_o,
  input  logic [DW-1:0] sr_rdata_i,
  output logic [AW-1:0] wr_addr_o,
  input  logic          wr_grant_i
);
  logic hold_s, cs_s, si_s, sck_s;

  spi_mem_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1100)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({hold_ni, cs_ni, si_i, sck_i}),
    .q_o    ({hold_s, cs_s, si_s, sck_s})
  );

  logic sck_d, cs_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_d <= 1'b0;
      cs_q  <= 1'b1;
    end else begin
      sck_d <= sck_s;
      if (hold_s) cs_q <= cs_s;  // select changes ignored during hold
    end
  end

  logic sck_rise, sck_fall, cs_rise, cs_fall;
  assign sck_rise = hold_s & sck_s & ~sck_d;
  assign sck_fall = hold_s & ~sck_s & sck_d;
  assign cs_rise  = hold_s & cs_s & ~cs_q;
  assign cs_fall  = hold_s & ~cs_s & cs_q;

  st_e           st;
  logic [CW-1:0] bit_cnt;
  logic [DW-2:0] in_sh;
  logic [DW-1:0] out_sh;
  logic [AW-1:0] addr;
  logic          rd_op;
  logic          so_q;

  logic [DW-1:0] byte_in;
  logic          shifting, byte_done;
  assign byte_in   = {in_sh, si_s};
  assign shifting  = sck_rise & (st != ST_IDLE) & (st != ST_SKIP);
  assign byte_done = shifting & (bit_cnt == CW'(DW-1));

  logic          mem_we;
  logic [AW-1:0] raddr;
  logic [DW-1:0] rdata;
  assign mem_we = byte_done & (st == ST_WDATA) & wr_grant_i;
  assign raddr  = (st == ST_ADDR) ? {addr[AW-1], byte_in} : addr + AW'(1);

  spi_mem_array #(.AW(AW), .DW(DW)) u_array (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (mem_we),
    .waddr_i (addr),
    .wdata_i (byte_in),
    .raddr_i (raddr),
    .rdata_o (rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st         <= ST_IDLE;
      bit_cnt    <= '0;
      in_sh      <= '0;
      out_sh     <= '0;
      addr       <= '0;
      rd_op      <= 1'b0;
      so_q       <= 1'b0;
      wel_set_o  <= 1'b0;
      wel_clr_o  <= 1'b0;
      sr_wr_o    <= 1'b0;
      sr_wdata_o <= '0;
    end else begin
      wel_set_o <= 1'b0;
      wel_clr_o <= 1'b0;
      sr_wr_o   <= 1'b0;
      if (cs_rise) begin
        st <= ST_IDLE;
      end else if (cs_fall) begin
        st      <= ST_OP;
        bit_cnt <= '0;
      end else if (shifting) begin
        in_sh   <= byte_in[DW-2:0];
        bit_cnt <= bit_cnt + CW'(1);
        if (byte_done) begin
          unique case (st)
            ST_OP: begin
              if (byte_in == CMD_LATCH_SET) begin
                wel_set_o <= 1'b1;
                st        <= ST_SKIP;
              end else if (byte_in == CMD_LATCH_CLR) begin
                wel_clr_o <= 1'b1;
                st        <= ST_SKIP;
              end else if (byte_in == CMD_STAT_RD) begin
                out_sh <= sr_rdata_i;
                st     <= ST_RDSR;
              end else if (byte_in == CMD_STAT_WR) begin
                st <= ST_WRSR;
              end else if (byte_in[7:4] == 4'h0 && byte_in[2:1] == 2'b01) begin
                addr[AW-1] <= byte_in[3];  // address MSB rides in the command
                rd_op      <= byte_in[0];
                st         <= ST_ADDR;
              end else begin
                st <= ST_SKIP;
              end
            end
            ST_ADDR: begin
              addr[DW-1:0] <= byte_in;
              if (rd_op) begin
                out_sh <= rdata;
                st     <= ST_RDATA;
              end else begin
                st <= ST_WDATA;
              end
            end
            ST_WDATA: addr <= addr + AW'(1);
            ST_RDATA: begin
              addr   <= addr + AW'(1);
              out_sh <= rdata;
            end
            ST_RDSR: st <= ST_SKIP;
            ST_WRSR: begin
              sr_wdata_o <= byte_in;
              sr_wr_o    <= 1'b1;
              st         <= ST_SKIP;
            end
            default: st <= ST_SKIP;
          endcase
        end
      end
      if (sck_fall && (st == ST_RDATA || st == ST_RDSR)) begin
        so_q   <= out_sh[DW-1];
        out_sh <= {out_sh[DW-2:0], 1'b0};
      end
    end
  end

  assign so_o      = so_q;
  assign so_oe_o   = hold_s & (st == ST_RDATA || st == ST_RDSR);
  assign wr_addr_o = addr;
endmodule

// File: rtl/spi_mem_slave_chk.sv
module spi_mem_slave_chk
  import spi_mem_pkg::*;
#(
  parameter int AW = 9
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          hold_s,
  input logic          cs_rise,
  input logic          byte_done,
  input st_e           st,
  input logic [AW-1:0] addr,
  input logic          so_oe_o,
  input logic          wel_set_o,
  input logic          wel_clr_o,
  input logic          sr_wr_o
);
  logic addr_step;
  assign addr_step = byte_done && (st == ST_WDATA || st == ST_RDATA);

  p_oe_off_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hold_s |-> !so_oe_o);

  p_frozen_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hold_s ##1 !hold_s |-> $stable(st) && $stable(addr));

  p_cs_end_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_rise |=> (st == ST_IDLE) && !so_oe_o);

  p_one_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({wel_set_o, wel_clr_o, sr_wr_o}));

  p_addr_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_step |=> addr == $past(addr) + AW'(1));

  p_addr_wrap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_step && (addr == {AW{1'b1}}) |=> addr == '0);
endmodule

bind spi_mem_slave spi_mem_slave_chk #(.AW(AW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .hold_s    (hold_s),
  .cs_rise   (cs_rise),
  .byte_done (byte_done),
  .st        (st),
  .addr      (addr),
  .so_oe_o   (so_oe_o),
  .wel_set_o (wel_set_o),
  .wel_clr_o (wel_clr_o),
  .sr_wr_o   (sr_wr_o)
);

// File: tb/sim_spi_mem_slave.sv
module sim_spi_mem_slave;
  localparam int CLK_P = 10;
  localparam int HALF  = 8;

  logic clk = 0, rst_n = 0;
  logic sck = 0, cs_n = 1, si = 0, hold_n = 1;
  logic so, so_oe, wel_set, wel_clr, sr_wr, grant_en;
  logic [7:0] sr_wdata, sr_rdata;
  logic [8:0] wr_addr;

  always #(CLK_P/2) clk = ~clk;

  spi_mem_slave u0 (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .cs_ni(cs_n), .si_i(si),
    .hold_ni(hold_n), .so_o(so), .so_oe_o(so_oe), .wel_set_o(wel_set),
    .wel_clr_o(wel_clr), .sr_wr_o(sr_wr), .sr_wdata_o(sr_wdata),
    .sr_rdata_i(sr_rdata), .wr_addr_o(wr_addr),
    .wr_grant_i(grant_en && (wr_addr < 9'h180))
  );

  int nchk = 0, nerr = 0;
  int n_set = 0, n_clr = 0, n_srw = 0;
  logic [7:0] model [512];

  always @(posedge clk) begin
    if (wel_set) n_set++;
    if (wel_clr) n_clr++;
    if (sr_wr)   n_srw++;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] tx, input logic exp_oe,
                      output logic [7:0] rx, output logic oe_ok);
    oe_ok = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      sck = 0; si = tx[i];
      tick(HALF);
      rx[i] = so;
      if (so_oe !== exp_oe) oe_ok = 1'b0;
      sck = 1;
      tick(HALF);
    end
  endtask

  task automatic sel(input bit m3);
    sck = m3; tick(HALF); cs_n = 0; tick(HALF);
  endtask

  task automatic desel(input bit m3);
    if (!m3) begin sck = 0; tick(HALF); end
    cs_n = 1; tick(2*HALF);
  endtask

  task automatic do_write(input bit m3, input logic [8:0] a, input logic [7:0] d[$]);
    logic [7:0] rx; logic ok; logic [8:0] p;
    sel(m3);
    xfer({4'h0, a[8], 3'b010}, 1'b0, rx, ok);
    xfer(a[7:0], 1'b0, rx, ok);
    p = a;
    foreach (d[k]) begin
      xfer(d[k], 1'b0, rx, ok);
      chk(ok, "R8 oe during write", 0, 0);
      if (grant_en && p < 9'h180) model[p] = d[k];
      p = p + 9'd1;
    end
    desel(m3);
  endtask

  task automatic do_read(input bit m3, input logic [8:0] a, input int n, input string tag);
    logic [7:0] rx; logic ok; logic [8:0] p;
    sel(m3);
    xfer({4'h0, a[8], 3'b011}, 1'b0, rx, ok);
    chk(ok, "R8 oe low in command byte", 0, 0);
    xfer(a[7:0], 1'b0, rx, ok);
    chk(ok, "R8 oe low in address byte", 0, 0);
    p = a;
    for (int k = 0; k < n; k++) begin
      xfer(8'hA5, 1'b1, rx, ok);  // SI ignored during read data (R7)
      chk(ok && rx == model[p], tag, rx, model[p]);
      p = p + 9'd1;
    end
    desel(m3);
  endtask

  initial begin
    #(CLK_P * 150000);
    nerr++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    logic [7:0] rx; logic ok;
    for (int i = 0; i < 512; i++) model[i] = 8'h00;
    grant_en = 1'b1;
    sr_rdata = 8'h4A;
    tick(5);
    chk(so_oe === 1'b0 && wel_set === 1'b0 && sr_wr === 1'b0, "reset outputs", so_oe, 0);
    rst_n = 1;
    tick(5);

    // R2 / R9: latch set plus a trailing byte, mode 0
    sel(0);
    xfer(8'h06, 1'b0, rx, ok);
    xfer(8'h04, 1'b0, rx, ok);
    desel(0);
    chk(n_set == 1 && n_clr == 0, "R2 R9 latch set once, trailing byte ignored", n_set*16+n_clr, 16);

    // R2: latch clear, mode 3
    sel(1);
    xfer(8'h04, 1'b0, rx, ok);
    desel(1);
    chk(n_clr == 1 && n_set == 1, "R2 latch clear mode3", n_clr, 1);

    // R4: status write
    sel(0);
    xfer(8'h01, 1'b0, rx, ok);
    xfer(8'h8C, 1'b0, rx, ok);
    xfer(8'h33, 1'b0, rx, ok);
    desel(0);
    chk(n_srw == 1 && sr_wdata == 8'h8C, "R4 status byte", sr_wdata, 8'h8C);

    // R3: status read, then high-impedance
    sel(1);
    xfer(8'h05, 1'b0, rx, ok);
    chk(ok, "R8 oe low during status command", 0, 0);
    xfer(8'h00, 1'b1, rx, ok);
    chk(ok && rx == 8'h4A, "R3 status read value", rx, 8'h4A);
    xfer(8'h00, 1'b0, rx, ok);
    chk(ok, "R3 oe low after status byte", so_oe, 0);
    desel(1);

    // R5 R6 R7: streamed write across the wrap, read back in both modes
    do_write(0, 9'h1FE, '{8'h11, 8'h22, 8'h33, 8'h44});
    do_read(0, 9'h1FE, 4, "R5 R7 wrap read mode0");
    do_read(1, 9'h1FF, 2, "R1 R7 read mode3");
    do_write(1, 9'h0F0, '{8'hC3, 8'h5A});
    do_read(0, 9'h0F0, 2, "R1 R5 mode3 write mode0 read");
    chk(model[9'h000] == 8'h33, "R7 wrap landed at 000", model[0], 8'h33);

    // R6: grant denied above 17F
    do_write(0, 9'h17E, '{8'hAA, 8'hBB, 8'hCC});
    do_read(1, 9'h17E, 3, "R6 protected byte unchanged");
    grant_en = 1'b0;
    do_write(0, 9'h010, '{8'h99});
    do_read(0, 9'h010, 1, "R6 no grant no write");
    grant_en = 1'b1;

    // R11 / R9: unknown command followed by a would-be read
    sel(0);
    xfer(8'h07, 1'b0, rx, ok); chk(ok, "R11 oe low unknown cmd", 0, 0);
    xfer(8'h03, 1'b0, rx, ok); chk(ok, "R9 second command ignored", 0, 0);
    xfer(8'hFE, 1'b0, rx, ok);
    xfer(8'h00, 1'b0, rx, ok); chk(ok, "R11 no data returned", so_oe, 0);
    desel(0);

    // R10: hold in the middle of a read
    sel(0);
    xfer(8'h0B, 1'b0, rx, ok);  // read, A8=1
    xfer(8'hFE, 1'b0, rx, ok);
    xfer(8'h00, 1'b1, rx, ok);
    chk(ok && rx == model[9'h1FE], "R10 byte before hold", rx, model[9'h1FE]);
    sck = 0; tick(HALF);
    hold_n = 0; tick(HALF);
    chk(so_oe === 1'b0, "R10 oe low during hold", so_oe, 0);
    for (int j = 0; j < 3; j++) begin
      sck = 1; tick(HALF); sck = 0; tick(HALF);
    end
    cs_n = 1; tick(HALF); cs_n = 0; tick(HALF);
    hold_n = 1; tick(HALF);
    xfer(8'h00, 1'b1, rx, ok);
    chk(ok && rx == model[9'h1FF], "R10 resume next byte", rx, model[9'h1FF]);
    xfer(8'h00, 1'b1, rx, ok);
    chk(ok && rx == model[9'h000], "R10 R7 resume wraps", rx, model[9'h000]);
    desel(0);
    chk(n_set == 1 && n_clr == 1 && n_srw == 1, "R9 no stray command pulses", n_set+n_clr+n_srw, 3);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule